// File: doc/BRIEF.md
# TDM Frame Offset Aligner

This block produces the per-lane frame timing for a four-lane serial PCM (TDM) port. A single frame-sync pulse, one bit-clock cycle wide, marks position zero of every frame. Each receive lane finds its own bit 0 at a programmable distance from that pulse. The distance is a shared ten-bit coarse delay plus a three-bit fine shift that belongs to that lane alone. Each transmit lane then places its own bit 0 a second ten-bit distance after the receive bit 0 of the same lane. All distances are counted in bit-clock periods and fold modulo the frame length.

For every lane the block emits a receive frame-start strobe, a receive bit counter, a transmit frame-start strobe, a transmit bit counter, and a transmit drive enable for the pad driver. When the enable is low, the pad driver holds the lane at high impedance. Settings are written through a narrow byte-wide write port into staging registers. The staged values are copied into the working set on the next frame-sync pulse, so a frame already in progress keeps its timing.

Top module: `tdm_frame_aligner`

## Requirements
- R1: During reset and afterwards, until the first `fsync` is sampled high, every strobe and every bit of `tx_oe` is 0; all settings reset to zero.
- R2: If `fsync` is sampled high in cycle t, then `rx_start[i]` is high in cycle t+D+1, where D = (IOFF + SHIFT_i) mod FRAME_BITS; with no further sync it repeats every FRAME_BITS cycles.
- R3: IOFF + SHIFT_i is formed without truncation to ten bits (IOFF=1023 with SHIFT=7 gives 1030 before folding), and each lane uses only its own shift.
- R4: Every delay and position folds modulo FRAME_BITS, so offsets of FRAME_BITS or more wrap inside the frame.
- R5: `rx_bitcnt[i]` is 0 in a cycle where `rx_start[i]` is high and otherwise counts up by one, wrapping from FRAME_BITS-1 to 0.
- R6: Once lane i has produced a receive start, `tx_start[i]` is high exactly when `rx_bitcnt[i]` equals OOFF mod FRAME_BITS, i.e. OOFF mod FRAME_BITS cycles after the receive start.
- R7: `tx_bitcnt[i]` is 0 in a cycle where `tx_start[i]` is high and otherwise counts up by one, wrapping from FRAME_BITS-1 to 0.
- R8: `tx_oe[i]` follows bit i of the enable register; 0 means the lane is not driven (high impedance), 1 means it drives.
- R9: A write changes only a staging copy. The new value governs timing from the cycle in which the next `fsync` is sampled (outputs from the following cycle), and it does not affect the frame in progress.
- R10: Register map at `cfg_addr`: 0 holds IOFF[9:2]; 1 holds IOFF[1:0] in bits 1:0 and OOFF[1:0] in bits 5:4; 2 holds OOFF[9:2]; 3 holds the enables in bits 3:0; 4 holds SHIFT_0 in bits 2:0 and SHIFT_1 in bits 6:4; 5 holds SHIFT_2 in bits 2:0 and SHIFT_3 in bits 6:4. Bits 7 and 3 of a shift register and writes to addresses 6 and 7 have no effect.
- R11: An `fsync` sampled in mid-frame restarts the frame position at zero in that cycle, whatever the previous count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, one cycle wide |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| rx_start | output | LANES | Receive frame-start strobe per lane |
| rx_bitcnt | output | LANES*CW | Receive bit position per lane, lane i in bits i*CW +: CW |
| tx_start | output | LANES | Transmit frame-start strobe per lane |
| tx_bitcnt | output | LANES*CW | Transmit bit position per lane, lane i in bits i*CW +: CW |
| tx_oe | output | LANES | Transmit drive enable per lane (0 = high impedance) |

## Verification
The bench builds the block with FRAME_BITS=64 and the default four lanes. Offset folding then takes effect within every frame: IOFF=1023 plus shift 7 folds to 6, and an output offset of 1000 folds to 40. The short frame also puts counter wrap-around, resync in mid-frame and frames longer than the counter range within a few thousand cycles. Writes that land in the middle of a frame probe the staging rule, because a changed offset can only be seen to wait for the sync when the old and new positions differ inside one frame.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;
  localparam int OFF_W  = 10;            // coarse offset width
  localparam int SH_W   = 3;             // per-lane fine shift width
  localparam int DLY_W  = OFF_W + 1;     // offset + shift without loss
  localparam int LO_W   = OFF_W - 8;     // offset bits held in the shared low register
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_IOFF_HI = 3'd0;
  localparam logic [ADDR_W-1:0] REG_OFF_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_OOFF_HI = 3'd2;
  localparam logic [ADDR_W-1:0] REG_OE      = 3'd3;
  localparam int                REG_SH_BASE = 4;   // one register per lane pair

  // frame position one bit period later, folded into the frame
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned frame);
    return (v + 1 >= frame) ? 0 : v + 1;
  endfunction

  // receive delay of a lane: coarse offset plus fine shift, folded
  function automatic int unsigned total_delay(input logic [OFF_W-1:0] off,
                                              input logic [SH_W-1:0] sh,
                                              input int unsigned frame);
    logic [DLY_W-1:0] s;
    s = DLY_W'(off) + DLY_W'(sh);
    return 32'(s) % frame;
  endfunction

  function automatic int unsigned frame_mod(input logic [OFF_W-1:0] v, input int unsigned frame);
    return 32'(v) % frame;
  endfunction
endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
  import tdm_align_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fsync,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [OFF_W-1:0]        ioff_now,
  output logic [OFF_W-1:0]        ooff_now,
  output logic [LANES*SH_W-1:0]   sh_now,
  output logic [LANES-1:0]        oe_q
);
  logic [OFF_W-1:0]      st_ioff, st_ooff, act_ioff, act_ooff;
  logic [LANES*SH_W-1:0] st_sh, act_sh;
  logic [LANES-1:0]      st_oe, oe_now;

  // staging copy: written at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ioff <= '0;
      st_ooff <= '0;
      st_sh   <= '0;
      st_oe   <= '0;
    end else if (we) begin
      case (addr)
        REG_IOFF_HI: st_ioff[OFF_W-1:LO_W] <= wdata;
        REG_OFF_LO: begin
          st_ioff[LO_W-1:0] <= wdata[LO_W-1:0];
          st_ooff[LO_W-1:0] <= wdata[4 +: LO_W];
        end
        REG_OOFF_HI: st_ooff[OFF_W-1:LO_W] <= wdata;
        REG_OE:      st_oe <= wdata[LANES-1:0];
        default: ;
      endcase
      for (int k = 0; k < LANES; k++) begin
        if (addr == ADDR_W'(REG_SH_BASE + k / 2))
          st_sh[k*SH_W +: SH_W] <= wdata[(k % 2) * 4 +: SH_W];
      end
    end
  end

  // working set: the staged values take over in the sync cycle itself
  assign ioff_now = fsync ? st_ioff : act_ioff;
  assign ooff_now = fsync ? st_ooff : act_ooff;
  assign sh_now   = fsync ? st_sh   : act_sh;
  assign oe_now   = fsync ? st_oe   : oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ioff <= '0;
      act_ooff <= '0;
      act_sh   <= '0;
      oe_q     <= '0;
    end else begin
      act_ioff <= ioff_now;
      act_ooff <= ooff_now;
      act_sh   <= sh_now;
      oe_q     <= oe_now;
    end
  end

  // R9: the working set only moves on a sync pulse
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> ($stable(act_ioff) && $stable(act_ooff) && $stable(act_sh)));
  // R8: the drive enables only move on a sync pulse
  assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> $stable(oe_q));
endmodule

// File: rtl/tdm_sync_pos.sv
module tdm_sync_pos
  import tdm_align_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1024,
  parameter int          CW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic [CW-1:0] pos_now,
  output logic          synced_now
);
  logic [CW-1:0] pos_q;
  logic          synced_q;

  // the sync cycle is position zero
  assign pos_now    = fsync ? '0 : pos_q;
  assign synced_now = fsync | synced_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      pos_q    <= CW'(wrap_inc(32'(pos_now), FRAME_BITS));
      synced_q <= synced_now;
    end
  end

  // R11: a sync pulse restarts the count wherever it stood
  assert_pos_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (32'(pos_q) == wrap_inc(0, FRAME_BITS)));
  // R4: the position never leaves the frame
  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pos_q) < FRAME_BITS);
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
  import tdm_align_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1024,
  parameter int          CW         = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    pos_now,
  input  logic             synced_now,
  input  logic [OFF_W-1:0] ioff_now,
  input  logic [SH_W-1:0]  sh_now,
  input  logic [OFF_W-1:0] ooff_now,
  output logic             rx_start,
  output logic [CW-1:0]    rx_bitcnt,
  output logic             tx_start,
  output logic [CW-1:0]    tx_bitcnt
);
  logic          rx_hit, tx_hit, run_q, run_d, txrun_q;
  logic [CW-1:0] rx_d, tx_d;

  // receive bit 0: frame position reaches offset + shift
  assign rx_hit = synced_now && (32'(pos_now) == total_delay(ioff_now, sh_now, FRAME_BITS));
  assign rx_d   = rx_hit ? '0 : CW'(wrap_inc(32'(rx_bitcnt), FRAME_BITS));
  assign run_d  = run_q | rx_hit;

  // transmit bit 0: receive count reaches the output offset
  assign tx_hit = run_d && (32'(rx_d) == frame_mod(ooff_now, FRAME_BITS));
  assign tx_d   = tx_hit ? '0 : CW'(wrap_inc(32'(tx_bitcnt), FRAME_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_start  <= 1'b0;
      rx_bitcnt <= '0;
      run_q     <= 1'b0;
      tx_start  <= 1'b0;
      tx_bitcnt <= '0;
      txrun_q   <= 1'b0;
    end else begin
      rx_start  <= rx_hit;
      rx_bitcnt <= rx_d;
      run_q     <= run_d;
      tx_start  <= tx_hit;
      tx_bitcnt <= tx_d;
      txrun_q   <= txrun_q | tx_hit;
    end
  end

  // R5: between starts the receive count steps by one
  assert_rx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !rx_start) |-> (32'(rx_bitcnt) == wrap_inc(32'($past(rx_bitcnt)), FRAME_BITS)));
  // R6: no transmit start before the lane has a receive frame
  assert_tx_after_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> run_q);
  // R7: between starts the transmit count steps by one
  assert_tx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txrun_q && !tx_start) |-> (32'(tx_bitcnt) == wrap_inc(32'($past(tx_bitcnt)), FRAME_BITS)));
endmodule

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner
  import tdm_align_pkg::*;
#(
  parameter int          LANES      = 4,
  parameter int unsigned FRAME_BITS = 1024,
  parameter int          CW         = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [LANES-1:0]      rx_start,
  output logic [LANES*CW-1:0]   rx_bitcnt,
  output logic [LANES-1:0]      tx_start,
  output logic [LANES*CW-1:0]   tx_bitcnt,
  output logic [LANES-1:0]      tx_oe
);
  logic [OFF_W-1:0]      ioff_now, ooff_now;
  logic [LANES*SH_W-1:0] sh_now;
  logic [CW-1:0]         pos_now;
  logic                  synced_now;

  tdm_cfg_regs #(.LANES(LANES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ioff_now(ioff_now), .ooff_now(ooff_now), .sh_now(sh_now), .oe_q(tx_oe)
  );

  tdm_sync_pos #(.FRAME_BITS(FRAME_BITS), .CW(CW)) u_pos (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .pos_now(pos_now), .synced_now(synced_now)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tdm_lane #(.FRAME_BITS(FRAME_BITS), .CW(CW)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .pos_now(pos_now), .synced_now(synced_now),
      .ioff_now(ioff_now), .sh_now(sh_now[g*SH_W +: SH_W]), .ooff_now(ooff_now),
      .rx_start(rx_start[g]), .rx_bitcnt(rx_bitcnt[g*CW +: CW]),
      .tx_start(tx_start[g]), .tx_bitcnt(tx_bitcnt[g*CW +: CW])
    );
  end
endmodule

// File: tb/test_tdm_frame_aligner.sv
module test_tdm_frame_aligner;
  localparam int L  = 4;
  localparam int F  = 64;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [L-1:0] rx_start, tx_start, tx_oe;
  logic [L*CW-1:0] rx_bitcnt, tx_bitcnt;

  tdm_frame_aligner #(.LANES(L), .FRAME_BITS(F)) i_tdm_frame_aligner (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_start(rx_start), .rx_bitcnt(rx_bitcnt),
    .tx_start(tx_start), .tx_bitcnt(tx_bitcnt), .tx_oe(tx_oe));

  always #5 clk = ~clk;

  int unsigned n_chk = 0, n_err = 0;
  bit done = 1'b0, chk_on = 1'b0;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  // ---- reference model, built from the requirements ----
  int unsigned s_ioff, s_ooff, a_ioff, a_ooff, since;
  int unsigned s_sh[L], a_sh[L], bc[L], obc[L];
  logic [L-1:0] s_oe, a_oe, e_rx, e_tx;
  bit synced, run[L], orun[L];

  function automatic int unsigned bump(input int unsigned v);
    return (v + 1) % F;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s_ioff = 0; s_ooff = 0; a_ioff = 0; a_ooff = 0; since = 0;
      s_oe = '0; a_oe = '0; e_rx = '0; e_tx = '0; synced = 0;
      for (int i = 0; i < L; i++) begin
        s_sh[i] = 0; a_sh[i] = 0; bc[i] = 0; obc[i] = 0; run[i] = 0; orun[i] = 0;
      end
    end else begin
      if (fsync) begin
        a_ioff = s_ioff; a_ooff = s_ooff; a_oe = s_oe;
        for (int i = 0; i < L; i++) a_sh[i] = s_sh[i];
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: s_ioff = (s_ioff & 32'h3) | (int'(cfg_wdata) << 2);
          3'd1: begin
            s_ioff = (s_ioff & 32'h3fc) | (cfg_wdata & 8'h3);
            s_ooff = (s_ooff & 32'h3fc) | ((cfg_wdata >> 4) & 8'h3);
          end
          3'd2: s_ooff = (s_ooff & 32'h3) | (int'(cfg_wdata) << 2);
          3'd3: s_oe = cfg_wdata[L-1:0];
          3'd4: begin s_sh[0] = cfg_wdata & 8'h7; s_sh[1] = (cfg_wdata >> 4) & 8'h7; end
          3'd5: begin s_sh[2] = cfg_wdata & 8'h7; s_sh[3] = (cfg_wdata >> 4) & 8'h7; end
          default: ;
        endcase
      end
      if (fsync) begin since = 0; synced = 1; end
      else since = bump(since);
      for (int i = 0; i < L; i++) begin
        e_rx[i] = synced && (since == (a_ioff + a_sh[i]) % F);
        bc[i]   = e_rx[i] ? 0 : bump(bc[i]);
        run[i]  = run[i] | e_rx[i];
        e_tx[i] = run[i] && (bc[i] == a_ooff % F);
        obc[i]  = e_tx[i] ? 0 : bump(obc[i]);
        orun[i] = orun[i] | e_tx[i];
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check(rx_start == e_rx, "R2 rx_start", rx_start, e_rx);
      check(tx_start == e_tx, "R6 tx_start", tx_start, e_tx);
      check(tx_oe == a_oe, "R8 tx_oe", tx_oe, a_oe);
      for (int i = 0; i < L; i++) begin
        if (run[i])  check(rx_bitcnt[i*CW +: CW] == CW'(bc[i]), "R5 rx_bitcnt", rx_bitcnt[i*CW +: CW], bc[i]);
        if (orun[i]) check(tx_bitcnt[i*CW +: CW] == CW'(obc[i]), "R7 tx_bitcnt", tx_bitcnt[i*CW +: CW], obc[i]);
      end
    end
  end

  // ---- stimulus ----
  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sync_pulse();
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic frame(input int len);
    sync_pulse();
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic rand_frame();
    int r, len, nw;
    r = int'($urandom_range(0, 9));
    len = (r < 7) ? F : ((r < 9) ? int'($urandom_range(8, F - 1)) : int'($urandom_range(F + 1, F + 30)));
    sync_pulse();
    nw = int'($urandom_range(0, 3));
    for (int k = 0; k < nw; k++) wr(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
    repeat (len - 1 - nw) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1d0f5));
    repeat (3) @(negedge clk);
    check(rx_start == '0 && tx_start == '0, "R1 strobes in reset", {rx_start, tx_start}, 0);
    check(tx_oe == '0, "R1 enables in reset", tx_oe, 0);
    rst_n = 1'b1; chk_on = 1'b1;
    phase = "R1 no sync yet";
    repeat (20) @(negedge clk);
    check(rx_start == '0 && tx_start == '0, "R1 idle before sync", {rx_start, tx_start}, 0);

    phase = "R2 zero delay";
    frame(F); frame(F);
    @(negedge clk);
    phase = "R2 free run without sync";
    repeat (2 * F) @(negedge clk);

    phase = "R3 max offset plus shift 1030";
    wr(0, 8'hFF); wr(1, 8'h03); wr(4, 8'h77); wr(5, 8'h77);
    frame(F); frame(F);
    phase = "R3 per-lane shifts";
    wr(4, 8'h31); wr(5, 8'h75); wr(0, 8'h02);
    frame(F); frame(F);

    phase = "R4 offsets folded by frame";
    wr(0, 8'd25); wr(1, 8'h00); wr(2, 8'd250); wr(3, 8'h0F);
    frame(F); frame(F); frame(F);

    phase = "R8 enables pattern";
    wr(3, 8'hA5);
    frame(F); frame(F);

    phase = "R9 write waits for sync";
    wr(0, 8'd2); wr(1, 8'h00); wr(2, 8'd1);
    frame(F);
    sync_pulse();
    wr(0, 8'd10); wr(2, 8'd3);
    repeat (F - 3) @(negedge clk);
    frame(F);

    phase = "R10 reserved bits and empty addresses";
    wr(4, 8'h88); wr(5, 8'h8F); wr(6, 8'hFF); wr(7, 8'hFF); wr(1, 8'hCC);
    frame(F); frame(F);

    phase = "R11 early sync";
    frame(20); frame(5); frame(F); frame(37);

    phase = "R7 long frames wrap counters";
    frame(F + 20); frame(F);

    phase = "random R2 R4 R6 R9 R11";
    for (int n = 0; n < 60; n++) rand_frame();
    repeat (F) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (%s) actual=hung expected=done", phase);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule